// File: doc/BRIEF.md
# Normalized Restoring Binary Divider

This block divides one unsigned 64-bit operand by another and returns both the quotient and the remainder. It is sequential and performs one shift-and-subtract step per clock. Before it starts iterating, it counts the leading zeros of both operands. From those counts it works out how many quotient bits can be nonzero, and it runs only that many steps. Small quotients therefore finish in a few cycles. When the divisor has more significant bits than the dividend, the result is ready at once.

A client loads the operands and pulses `start` while the block is idle. `busy` stays high while steps are running. `done` pulses for one cycle when `quotient`, `remainder` and `div_by_zero` are valid. Those outputs then hold until the next operation completes. A zero divisor does not trap. It produces a fixed result and raises the error flag.

Top module: `ndiv_top`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor, the completed result satisfies `quotient` = floor(dividend/divisor) and `remainder` = dividend − quotient·divisor, so `remainder` < divisor.
- R3: Let sN and sD be the significant-bit counts of the dividend and divisor (position of the highest set bit plus one). When sN ≥ sD, the block runs k = sN − sD + 1 steps. The start-sampling edge is edge 0. `busy` is high for exactly the k cycles after edge 0, and `done` is set by edge k. `busy` and `done` are never high together.
- R4: Early exit. When the divisor is nonzero and the dividend has fewer significant bits (a zero dividend included), `done` is set by edge 0 itself. In that case `quotient` is 0, `remainder` equals the dividend, and `busy` never rises.
- R5: Division by zero. A zero divisor sets `div_by_zero` to 1, `quotient` to all ones and `remainder` to the dividend, with the same timing as R4. The next operation with a nonzero divisor clears the flag when it completes.
- R6: `done` is high for exactly one cycle per operation.
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands, its result and its step count.
- R8: Between completions, `quotient`, `remainder` and `div_by_zero` keep their values, whatever the operand inputs do.
- R9: The extreme cases finish correctly. An all-ones dividend over a divisor of 1 takes 64 steps and returns the dividend. Operands whose significant bits lie in different 32-bit halves also divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividend | input | 64 | Unsigned dividend, sampled with `start` |
| divisor | input | 64 | Unsigned divisor, sampled with `start` |
| busy | output | 1 | Shift-subtract steps in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | 64 | Quotient of the last completed operation |
| remainder | output | 64 | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
The bench targets the boundaries of the step count.

Equal operands and a dividend just below a divisor of the same width both need exactly one step. Getting the "+1" wrong would either skip that step or add a spurious quotient bit. An all-ones dividend over 1 needs the full 64 steps, which exposes a counter that is one bit too narrow or a pre-shift by the full width that goes wrong. Operands split across the two 32-bit halves catch a leading-zero count that mishandles the low-half fallback; such a count would leave the quotient badly misaligned.

Other scenarios check the rest of the contract:
- zero and smaller dividends must exit with no busy cycle;
- a zero divisor must give all ones and then clear its flag on the next good division;
- a mid-run `start` with new operands must change neither the result nor the latency;
- the result must stay put while the inputs wander.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

  typedef enum logic [0:0] {
    ND_IDLE = 1'b0,
    ND_RUN  = 1'b1
  } nd_state_e;

  typedef enum logic [1:0] {
    ND_KIND_ITER  = 2'd0,
    ND_KIND_EARLY = 2'd1,
    ND_KIND_ZERO  = 2'd2
  } nd_kind_e;

endpackage

// File: rtl/ndiv_lzc.sv
module ndiv_lzc #(
  parameter int W = 64
) (
  input  logic [W-1:0]             value,
  output logic [$clog2(W+1)-1:0]   zeros
);
  localparam int HW   = W / 2;
  localparam int LZW  = $clog2(W + 1);
  localparam int HLZW = $clog2(HW + 1);

  function automatic logic [HLZW-1:0] half_zeros(input logic [HW-1:0] v);
    logic [HLZW-1:0] c;
    c = HLZW'(HW);
    for (int i = 0; i < HW; i++) begin
      if (v[i]) c = HLZW'(HW - 1 - i);
    end
    return c;
  endfunction

  logic [HW-1:0]   hi_word;
  logic [HW-1:0]   lo_word;
  logic [HLZW-1:0] hi_zeros;
  logic [HLZW-1:0] lo_zeros;

  assign hi_word  = value[W-1:HW];
  assign lo_word  = value[HW-1:0];
  assign hi_zeros = half_zeros(hi_word);
  assign lo_zeros = half_zeros(lo_word);

  generate
    if (W % 2 == 0) begin : g_split
      always_comb begin
        if (hi_word != '0) zeros = LZW'(hi_zeros);
        else               zeros = LZW'(HW) + LZW'(lo_zeros);
      end
    end else begin : g_bad_width
      initial $error("ndiv_lzc: width must be even");
      assign zeros = '0;
    end
  endgenerate
endmodule

// File: rtl/ndiv_plan.sv
module ndiv_plan
  import ndiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]           dvd,
  input  logic [W-1:0]           dvs,
  input  logic [$clog2(W+1)-1:0] lz_dvd,
  input  logic [$clog2(W+1)-1:0] lz_dvs,
  output nd_kind_e               kind,
  output logic [$clog2(W+1)-1:0] steps,
  output logic [W-1:0]           part0,
  output logic [W-1:0]           rest0
);
  localparam int LZW = $clog2(W + 1);

  // significant-bit difference plus one equals lz_dvs - lz_dvd + 1
  function automatic logic [LZW-1:0] step_count(input logic [LZW-1:0] zn,
                                                input logic [LZW-1:0] zd);
    return zd - zn + LZW'(1);
  endfunction

  logic [LZW-1:0] rest_sh;

  assign steps   = step_count(lz_dvd, lz_dvs);
  assign rest_sh = LZW'(W) - steps;
  assign part0   = dvd >> steps;
  assign rest0   = dvd << rest_sh;

  always_comb begin
    if (dvs == '0)            kind = ND_KIND_ZERO;
    else if (lz_dvd > lz_dvs) kind = ND_KIND_EARLY;
    else                      kind = ND_KIND_ITER;
  end
endmodule

// File: rtl/ndiv_step.sv
module ndiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] part,
  input  logic         next_bit,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] part_nx,
  output logic         qbit
);
  // one restoring trial: returns {keep_flag, new partial remainder}
  function automatic logic [W:0] trial(input logic [W-1:0] p,
                                       input logic         b,
                                       input logic [W-1:0] d);
    logic [W:0] widened;
    logic [W:0] diff;
    widened = {p, b};
    diff    = widened - {1'b0, d};
    if (diff[W]) return {1'b0, widened[W-1:0]};
    else         return {1'b1, diff[W-1:0]};
  endfunction

  logic [W:0] res;

  assign res     = trial(part, next_bit, dvs);
  assign qbit    = res[W];
  assign part_nx = res[W-1:0];
endmodule

// File: rtl/ndiv_top.sv
module ndiv_top
  import ndiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int LZW = $clog2(W + 1);

  nd_state_e      state;
  logic [LZW-1:0] cnt;
  logic [W-1:0]   part;
  logic [W-1:0]   rest;
  logic [W-1:0]   qacc;
  logic [W-1:0]   dvs_q;
  logic [W-1:0]   quo_q;
  logic [W-1:0]   rem_q;
  logic           dz_q;
  logic           done_q;

  logic [LZW-1:0] lz_dvd;
  logic [LZW-1:0] lz_dvs;
  nd_kind_e       kind;
  logic [LZW-1:0] steps;
  logic [W-1:0]   part0;
  logic [W-1:0]   rest0;
  logic [W-1:0]   part_nx;
  logic           qbit;
  logic [W-1:0]   qacc_nx;

  // named events for the checker
  logic accept;
  logic load_fire;
  logic quick_fire;
  logic step_fire;
  logic step_last;

  ndiv_lzc #(.W(W)) u_lz_dvd (.value(dividend), .zeros(lz_dvd));
  ndiv_lzc #(.W(W)) u_lz_dvs (.value(divisor),  .zeros(lz_dvs));

  ndiv_plan #(.W(W)) u_plan (
    .dvd    (dividend),
    .dvs    (divisor),
    .lz_dvd (lz_dvd),
    .lz_dvs (lz_dvs),
    .kind   (kind),
    .steps  (steps),
    .part0  (part0),
    .rest0  (rest0)
  );

  ndiv_step #(.W(W)) u_step (
    .part     (part),
    .next_bit (rest[W-1]),
    .dvs      (dvs_q),
    .part_nx  (part_nx),
    .qbit     (qbit)
  );

  assign accept     = start && (state == ND_IDLE);
  assign load_fire  = accept && (kind == ND_KIND_ITER);
  assign quick_fire = accept && (kind != ND_KIND_ITER);
  assign step_fire  = (state == ND_RUN);
  assign step_last  = step_fire && (cnt == LZW'(1));
  assign qacc_nx    = {qacc[W-2:0], qbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ND_IDLE;
      cnt    <= '0;
      part   <= '0;
      rest   <= '0;
      qacc   <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dz_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ND_IDLE: begin
          if (accept) begin
            dvs_q <= divisor;
            unique case (kind)
              ND_KIND_ZERO: begin
                quo_q  <= '1;
                rem_q  <= dividend;
                dz_q   <= 1'b1;
                done_q <= 1'b1;
              end
              ND_KIND_EARLY: begin
                quo_q  <= '0;
                rem_q  <= dividend;
                dz_q   <= 1'b0;
                done_q <= 1'b1;
              end
              default: begin
                part  <= part0;
                rest  <= rest0;
                qacc  <= '0;
                cnt   <= steps;
                state <= ND_RUN;
              end
            endcase
          end
        end
        ND_RUN: begin
          part <= part_nx;
          rest <= rest << 1;
          qacc <= qacc_nx;
          cnt  <= cnt - LZW'(1);
          if (step_last) begin
            state  <= ND_IDLE;
            quo_q  <= qacc_nx;
            rem_q  <= part_nx;
            dz_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: state <= ND_IDLE;
      endcase
    end
  end

  assign busy        = step_fire;
  assign done        = done_q;
  assign quotient    = quo_q;
  assign remainder   = rem_q;
  assign div_by_zero = dz_q;
endmodule

// File: rtl/ndiv_chk.sv
module ndiv_chk #(
  parameter int W = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   div_by_zero,
  input logic [W-1:0]           quotient,
  input logic [W-1:0]           remainder,
  input logic [W-1:0]           dvs_q,
  input logic [$clog2(W+1)-1:0] cnt,
  input logic                   quick_fire,
  input logic                   step_fire,
  input logic                   step_last
);
  p_rem_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < dvs_q));

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (cnt != '0));

  p_early_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quick_fire |=> (done && !busy));

  p_zero_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (&quotient));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_keep_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_last) |=> busy);

  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> (done && !busy));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind ndiv_top ndiv_chk #(.W(W)) u_ndiv_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .div_by_zero (div_by_zero),
  .quotient    (quotient),
  .remainder   (remainder),
  .dvs_q       (dvs_q),
  .cnt         (cnt),
  .quick_fire  (quick_fire),
  .step_fire   (step_fire),
  .step_last   (step_last)
);

// File: tb/tb_ndiv_top.sv
`timescale 1ns/1ps
module tb_ndiv_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  ndiv_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int sig_bits(input logic [W-1:0] v);
    int s = 0;
    for (int i = 0; i < W; i++) if (v[i]) s = i + 1;
    return s;
  endfunction

  // Issue one operation and wait until done. Returns the negedge index at which
  // done was seen and the number of busy cycles before it.
  task automatic issue(input logic [W-1:0] n, input logic [W-1:0] d,
                       output int seen_at, output int busy_cycles);
    @(negedge clk);
    dividend = n; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen_at = 1; busy_cycles = 0;
    while (!done && seen_at < 300) begin
      if (busy) busy_cycles++;
      @(negedge clk);
      seen_at++;
    end
  endtask

  task automatic t_divide(input string tag, input logic [W-1:0] n, input logic [W-1:0] d);
    int at, bc, k;
    logic [W-1:0] eq, er;
    logic edz;
    issue(n, d, at, bc);
    if (d == '0) begin
      eq = '1; er = n; edz = 1'b1; k = 0;
    end else if (sig_bits(n) < sig_bits(d)) begin
      eq = '0; er = n; edz = 1'b0; k = 0;
    end else begin
      eq = n / d; er = n % d; edz = 1'b0; k = sig_bits(n) - sig_bits(d) + 1;
    end
    check(tag, "quotient",  quotient,  eq);
    check(tag, "remainder", remainder, er);
    check(tag, "div_by_zero", W'(div_by_zero), W'(edz));
    check("R3", {tag, " done edge"}, W'(at), W'(k + 1));
    check("R3", {tag, " busy cycles"}, W'(bc), W'(k));
    @(negedge clk);
    check("R6", {tag, " done low after pulse"}, W'(done), '0);
  endtask

  task automatic t_reset();
    check("R1", "busy",      W'(busy), '0);
    check("R1", "done",      W'(done), '0);
    check("R1", "dz flag",   W'(div_by_zero), '0);
    check("R1", "quotient",  quotient, '0);
    check("R1", "remainder", remainder, '0);
  endtask

  task automatic t_basic();
    t_divide("R2", 64'd100, 64'd7);
    t_divide("R2", 64'd7, 64'd7);
    t_divide("R2", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    t_divide("R2", 64'h0123_4567_89AB_CDEF, 64'd10);
  endtask

  task automatic t_extremes();
    t_divide("R9", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    t_divide("R9", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000);
    t_divide("R9", 64'hDEAD_BEEF_1234_5678, 64'h0000_0000_0000_0F0F);
    t_divide("R9", 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0001);
  endtask

  task automatic t_early();
    t_divide("R4", 64'd5, 64'h0000_0001_0000_0000);
    t_divide("R4", 64'd0, 64'd9);
    t_divide("R4", 64'h0000_0000_FFFF_FFFF, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_zero();
    t_divide("R5", 64'd1234, 64'd0);
    t_divide("R5", 64'd0, 64'd0);
    t_divide("R5", 64'd1000, 64'd3);
  endtask

  task automatic t_start_busy();
    int at, bc;
    @(negedge clk);
    dividend = 64'hFFFF_0000_FFFF_0000; divisor = 64'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    at = 1; bc = 0;
    repeat (3) begin
      if (busy) bc++;
      @(negedge clk); at++;
    end
    dividend = 64'd77; divisor = 64'd0; start = 1'b1;
    if (busy) bc++;
    @(negedge clk); at++;
    start = 1'b0;
    while (!done && at < 300) begin
      if (busy) bc++;
      @(negedge clk); at++;
    end
    check("R7", "quotient",  quotient,  64'hFFFF_0000_FFFF_0000 / 64'd3);
    check("R7", "remainder", remainder, 64'hFFFF_0000_FFFF_0000 % 64'd3);
    check("R7", "dz flag",   W'(div_by_zero), '0);
    check("R7", "done edge", W'(at), W'(64 - 2 + 1 + 1));
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    t_divide("R8", 64'd999_999, 64'd37);
    q0 = quotient; r0 = remainder;
    dividend = 64'd5; divisor = 64'd0;
    repeat (6) @(negedge clk);
    check("R8", "quotient held",  quotient,  q0);
    check("R8", "remainder held", remainder, r0);
    check("R8", "dz held",        W'(div_by_zero), '0);
    check("R8", "idle",           W'(busy), '0);
  endtask

  task automatic t_mixed();
    logic [W-1:0] s = 64'h9E37_79B9_7F4A_7C15;
    logic [W-1:0] a, b;
    for (int i = 0; i < 10; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      a = s >> (i * 3);
      b = (s * 64'd2654435761) >> (20 + i * 4);
      t_divide("R2", a, b);
    end
  endtask

  initial begin
    #750000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_extremes();
    t_early();
    t_zero();
    t_start_busy();
    t_hold();
    t_mixed();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule